// File: doc/BRIEF.md
# Microcode Store Boot Loader

At power-up this block fills the processor's microcode store from a byte-wide nonvolatile memory. The store is made of several byte-wide RAM lanes that share one write data byte and one write address while loading. A load counter starts at zero after reset and steps once per clock. Each count reads one byte from the nonvolatile memory, and the byte is written into one lane on the following clock.

When the last byte has been written, the counter stays where it is. The lanes then turn into one wide microinstruction word that the processor reads by word address. In the same cycle the block raises its done flag, the enable for the external interface and the enable for the system clock.

The microcode depth `DEPTH` (words per lane) and the lane count `LANES` are parameters, and both must be powers of two. The terminal count is `DEPTH*LANES-1`. With the defaults (64 words, 8 lanes) a full load reads 512 bytes and produces a 64-bit microword.

Top module: `ucode_boot_loader`

## Requirements
- R1: While `rstN` is low, `loadDone`, `extEn` and `sysClkEn` are 0, `ramWe` is all zeros and `uWord` is 0. In the first cycle after release, `nvRd` is 1 and `nvAddr` is 0.
- R2: While `nvRd` is 1, `nvAddr` increases by exactly one on every clock, starting from 0.
- R3: A byte presented on `nvData` while `nvAddr` = a is written one clock later, using exactly one write strobe.
- R4: For the write of byte a, `ramWe` is one-hot with bit a mod `LANES` set (the low address bits select the lane), `ramWrAddr` = a / `LANES` (the upper address bits), and `ramWrData` is the byte sampled from `nvData` at address a.
- R5: At most one bit of `ramWe` is ever set. Before the load completes, `ramCs` equals `ramWe`.
- R6: After `nvAddr` reaches `DEPTH*LANES-1`, `nvRd` drops to 0 on the next clock. The counter then holds `nvAddr` at that terminal value, and no write strobe follows the final byte.
- R7: `loadDone`, `extEn` and `sysClkEn` rise together in the cycle after the final write, which is `DEPTH*LANES+1` clocks after reset release. They stay high until the next reset.
- R8: Once `loadDone` is 1, `ramCs` is all ones and `ramWe` is all zeros. `uWord` carries, in bits [8i+7:8i], the byte loaded from address `uAddr*LANES + i`, one clock after `uAddr` is presented.
- R9: `uWord` stays 0 until the first clock edge at which `loadDone` is already 1.
- R10: Asserting reset part way through a load abandons it. After release, the load restarts from address 0 and runs to completion with the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nvAddr | output | log2(DEPTH*LANES) | Nonvolatile memory byte address |
| nvRd | output | 1 | Read enable towards the nonvolatile memory, high while loading |
| nvData | input | 8 | Byte read from the nonvolatile memory, valid in the same cycle as its address |
| ramCs | output | LANES | Lane chip selects |
| ramWe | output | LANES | Lane write strobes |
| ramWrAddr | output | log2(DEPTH) | Shared lane word address during loading |
| ramWrData | output | 8 | Shared lane write data |
| uAddr | input | log2(DEPTH) | Microword address from the processor |
| uWord | output | 8*LANES | Wide microinstruction word |
| loadDone | output | 1 | Load complete |
| extEn | output | 1 | External interface enable |
| sysClkEn | output | 1 | System clock enable |

## Verification
The assertions assume that the nonvolatile memory answers without wait states: the byte for an address is valid before the end of the cycle in which that address is driven. They also assume that reset is released away from the clock edge. The bench drives `nvData` combinationally from `nvAddr` using a seeded byte pattern and releases reset on the falling clock edge. It drives `uAddr` only to legal word addresses. It runs two full loads with different patterns and one load cut short by reset.

// File: rtl/ucode_boot_pkg.sv
package ucode_boot_pkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic capture;  // sample nvData and the current address this cycle
    logic commit;   // write the held byte into its lane this cycle
    logic run;      // load finished, lanes act as one wide word
  } ldStrobe_t;

endpackage

// File: rtl/ucode_boot_ctrl.sv
module ucode_boot_ctrl
  import ucode_boot_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int TOTAL  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] count,
  output ldStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(TOTAL - 1);

  logic loading;
  logic pendValid;
  logic done;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      loading   <= 1'b1;
      pendValid <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (loading) begin
        if (count == LastAddr) loading <= 1'b0;
        else                   count   <= count + 1'b1;
      end
      pendValid <= loading;
      if (pendValid && !loading) done <= 1'b1;
    end
  end

  always_comb begin
    strobe.capture = loading;
    strobe.commit  = pendValid;
    strobe.run     = done;
  end

endmodule

// File: rtl/ucode_boot_dp.sv
module ucode_boot_dp
  import ucode_boot_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WORD_AW = $clog2(DEPTH),
  localparam int ADDR_W = WORD_AW + LANE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ldStrobe_t                 strobe,
  input  logic [ADDR_W-1:0]         count,
  input  logic [BYTE_W-1:0]         nvData,
  input  logic [WORD_AW-1:0]        uAddr,
  output logic [LANES-1:0]          ramCs,
  output logic [LANES-1:0]          ramWe,
  output logic [WORD_AW-1:0]        ramWrAddr,
  output logic [BYTE_W-1:0]         ramWrData,
  output logic [LANES*BYTE_W-1:0]   uWord
);

  logic [BYTE_W-1:0]  heldData;
  logic [ADDR_W-1:0]  heldAddr;
  logic [LANE_W-1:0]  laneSel;

  // One cycle of holding lets the source byte settle before the write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldData <= '0;
      heldAddr <= '0;
    end else if (strobe.capture) begin
      heldData <= nvData;
      heldAddr <= count;
    end
  end

  assign laneSel   = heldAddr[LANE_W-1:0];
  assign ramWrAddr = heldAddr[ADDR_W-1:LANE_W];
  assign ramWrData = heldData;

  always_comb begin
    ramWe = '0;
    if (strobe.commit) ramWe[laneSel] = 1'b1;
    ramCs = strobe.run ? '1 : ramWe;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] bank [DEPTH];
    logic [BYTE_W-1:0] laneOut;

    always_ff @(posedge clk) begin
      if (ramWe[g]) bank[ramWrAddr] <= heldData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           laneOut <= '0;
      else if (strobe.run) laneOut <= bank[uAddr];
    end

    assign uWord[g*BYTE_W +: BYTE_W] = laneOut;
  end

endmodule

// File: rtl/ucode_boot_loader.sv
module ucode_boot_loader
  import ucode_boot_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  localparam int WORD_AW = $clog2(DEPTH),
  localparam int ADDR_W = WORD_AW + $clog2(LANES),
  localparam int TOTAL = DEPTH * LANES
) (
  input  logic                     clk,
  input  logic                     rstN,
  output logic [ADDR_W-1:0]        nvAddr,
  output logic                     nvRd,
  input  logic [BYTE_W-1:0]        nvData,
  output logic [LANES-1:0]         ramCs,
  output logic [LANES-1:0]         ramWe,
  output logic [WORD_AW-1:0]       ramWrAddr,
  output logic [BYTE_W-1:0]        ramWrData,
  input  logic [WORD_AW-1:0]       uAddr,
  output logic [LANES*BYTE_W-1:0]  uWord,
  output logic                     loadDone,
  output logic                     extEn,
  output logic                     sysClkEn
);

  ldStrobe_t         strobe;
  logic [ADDR_W-1:0] count;

  ucode_boot_ctrl #(.ADDR_W(ADDR_W), .TOTAL(TOTAL)) ctrl (
    .clk(clk), .rstN(rstN), .count(count), .strobe(strobe)
  );

  ucode_boot_dp #(.DEPTH(DEPTH), .LANES(LANES), .BYTE_W(BYTE_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count),
    .nvData(nvData), .uAddr(uAddr), .ramCs(ramCs), .ramWe(ramWe),
    .ramWrAddr(ramWrAddr), .ramWrData(ramWrData), .uWord(uWord)
  );

  assign nvAddr   = count;
  assign nvRd     = strobe.capture;
  assign loadDone = strobe.run;
  assign extEn    = strobe.run;
  assign sysClkEn = strobe.run;

endmodule

// File: rtl/ucode_boot_chk.sv
module ucode_boot_chk #(
  parameter int LANES  = 8,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] nvAddr,
  input logic              nvRd,
  input logic [LANES-1:0]  ramCs,
  input logic [LANES-1:0]  ramWe,
  input logic              loadDone,
  input logic              extEn,
  input logic              sysClkEn
);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    nvRd |=> (!nvRd || nvAddr == ADDR_W'($past(nvAddr) + 1)));

  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    nvRd |=> $countones(ramWe) == 1);

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ramWe));

  a_r6_counter_stops: assert property (@(posedge clk) disable iff (!rstN)
    !nvRd |=> !nvRd && $stable(nvAddr));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone && extEn && sysClkEn);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> $past(ramWe) != '0);

  a_r8_parallel_mode: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (ramCs == {LANES{1'b1}}) && (ramWe == '0));

endmodule

bind ucode_boot_loader ucode_boot_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .nvAddr(nvAddr), .nvRd(nvRd), .ramCs(ramCs),
  .ramWe(ramWe), .loadDone(loadDone), .extEn(extEn), .sysClkEn(sysClkEn)
);

// File: tb/ucode_boot_loader_test.sv
module ucode_boot_loader_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LANES = 8;
  localparam int TOTAL = DEPTH * LANES;
  localparam int WORD_AW = $clog2(DEPTH);
  localparam int ADDR_W = $clog2(TOTAL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] nvAddr;
  logic nvRd;
  logic [7:0] nvData;
  logic [LANES-1:0] ramCs, ramWe;
  logic [WORD_AW-1:0] ramWrAddr, uAddr;
  logic [7:0] ramWrData;
  logic [LANES*8-1:0] uWord;
  logic loadDone, extEn, sysClkEn;

  int checks = 0;
  int fails = 0;
  logic [7:0] seed = 8'h00;
  int prevU = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_boot_loader uut (
    .clk(clk), .rstN(rstN), .nvAddr(nvAddr), .nvRd(nvRd), .nvData(nvData),
    .ramCs(ramCs), .ramWe(ramWe), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .uAddr(uAddr), .uWord(uWord), .loadDone(loadDone), .extEn(extEn),
    .sysClkEn(sysClkEn)
  );

  function automatic logic [7:0] pat(logic [7:0] s, int a);
    return 8'((a * 37) + (a >> 3) * 11 + s) ^ s;
  endfunction

  always_comb nvData = pat(seed, int'(nvAddr));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural expectation for c clocks after reset release
  task automatic checkCycle(int c);
    logic expRd, expDone, expWr;
    int a;
    logic [LANES-1:0] expWe;
    logic [63:0] expWord;
    expRd   = (c < TOTAL);
    expDone = (c >= TOTAL + 1);
    expWr   = (c >= 1) && (c <= TOTAL);
    a       = c - 1;
    expWe   = expWr ? LANES'(1 << (a % LANES)) : '0;
    check("R2 nvRd", 64'(nvRd), 64'(expRd));
    check("R2/R6 nvAddr", 64'(nvAddr), 64'((c < TOTAL) ? c : TOTAL - 1));
    check("R3/R4/R6 ramWe", 64'(ramWe), 64'(expWe));
    if (expWr) begin
      check("R4 ramWrAddr", 64'(ramWrAddr), 64'(a / LANES));
      check("R4 ramWrData", 64'(ramWrData), 64'(pat(seed, a)));
    end
    check("R5/R8 ramCs", 64'(ramCs), 64'(expDone ? {LANES{1'b1}} : expWe));
    check("R7 loadDone", 64'(loadDone), 64'(expDone));
    check("R7 extEn", 64'(extEn), 64'(expDone));
    check("R7 sysClkEn", 64'(sysClkEn), 64'(expDone));
    expWord = '0;
    if (c >= TOTAL + 2)
      for (int i = 0; i < LANES; i++) expWord[i*8 +: 8] = pat(seed, prevU * LANES + i);
    check((c >= TOTAL + 2) ? "R8 uWord" : "R9 uWord", uWord, expWord);
  endtask

  task automatic runPass(logic [7:0] s, int cycles, string tag);
    rstN = 1'b0;
    seed = s;
    uAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({"R1 reset loadDone ", tag}, 64'(loadDone), 64'(0));
    check({"R1 reset ramWe ", tag}, 64'(ramWe), 64'(0));
    check({"R1 reset uWord ", tag}, uWord, 64'(0));
    rstN = 1'b1;
    #1;
    checkCycle(0);
    for (int c = 1; c <= cycles; c++) begin
      uAddr = WORD_AW'($urandom_range(0, DEPTH - 1));
      prevU = int'(uAddr);
      @(negedge clk);
      checkCycle(c);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    runPass(8'h5a, TOTAL + 60, "pass1");
    runPass(8'hc3, 150, "R10 abort");
    runPass(8'h17, TOTAL + 60, "R10 reload");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule